// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit operands and a carry input without any carry ripple. The operand is cut into four 4-bit slices. Each slice forms a per-bit generate (AND of the operand bits) and a per-bit propagate (OR of the operand bits). From its single carry-in, it then computes every internal carry at once as an expanded sum of products. It produces its four sum bits and a slice-level generate/propagate pair.

A second lookahead unit takes the four slice pairs and the external carry-in. It computes the carry into each slice directly and also produces a group generate/propagate pair for the whole word. These two signals let a further lookahead level combine several of these adders. The carry out of the word is built from the group pair and the carry-in. The block is purely combinational; the slice width and slice count are parameters.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_in + b_in + c_in` for every operand pair.
- R2: `c_out` equals bit 16 of `a_in + b_in + c_in`; the all-ones operand plus a carry-in of 1 gives `sum_o` = 0 and `c_out` = 1.
- R3: `grp_gen` is 1 exactly when `a_in + b_in` (without carry-in) is at least 2^16.
- R4: `grp_prop` is 1 exactly when every bit position has at least one operand bit set, i.e. `&(a_in | b_in)`.
- R5: `c_out` equals `grp_gen | (grp_prop & c_in)`.
- R6: The carry entering each slice (bit positions 4, 8 and 12) comes from the group lookahead unit and equals the carry out of adding all lower bits plus `c_in`; a carry crossing a slice boundary (for example 0x000F + 0x0001) lands in the next slice.
- R7: A carry-in of 1 travels the full word when every position only propagates (0xFFFF + 0x0000): with `c_in` = 0 the result is 0xFFFF and `c_out` = 0, with `c_in` = 1 the result is 0x0000 and `c_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | Word-level carry generate for a further lookahead level |
| grp_prop | output | 1 | Word-level carry propagate for a further lookahead level |

## Verification
The hardest case to reach from the ports is a carry that is neither generated nor killed anywhere. In that case it has to cross every slice boundary through the group unit, and random operands almost never produce it. The stimulus therefore includes directed all-propagate patterns such as 0xFFFF + 0x0000 and 0xFFFF + 0x0001, and single-boundary patterns such as 0x000F + 0x0001. A second instance with two 2-bit slices is swept over every operand and carry combination. That sweep covers every generate/propagate/kill mix at both lookahead levels.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
    // per-slice lookahead pair handed to the upper level
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;
endpackage

// File: rtl/cla2_lcu.sv
// Generic lookahead carry unit: every carry is a flat sum of products of
// generate/propagate terms and the carry-in, with no chaining.
module cla2_lcu #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o,   // carry into position k (carry_o[0] = cin_i)
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [N-1:0] carry_d;
    logic         gg_d;
    logic         gp_d;

    always_comb begin
        carry_d = '0;
        for (int j = 0; j < N; j++) begin
            logic term;
            logic acc;
            acc = 1'b0;
            for (int k = 0; k < j; k++) begin
                term = gen_i[k];
                for (int m = k + 1; m < j; m++) begin
                    term = term & prop_i[m];
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int m = 0; m < j; m++) begin
                term = term & prop_i[m];
            end
            carry_d[j] = acc | term;
        end
    end

    always_comb begin
        gg_d = 1'b0;
        gp_d = 1'b1;
        for (int k = 0; k < N; k++) begin
            logic term;
            term = gen_i[k];
            for (int m = k + 1; m < N; m++) begin
                term = term & prop_i[m];
            end
            gg_d = gg_d | term;
            gp_d = gp_d & prop_i[k];
        end
    end

    assign carry_o    = carry_d;
    assign grp_gen_o  = gg_d;
    assign grp_prop_o = gp_d;
endmodule

// File: rtl/cla2_slice.sv
// One lookahead slice: bit generate/propagate, flat carries, sum bits,
// and the slice-level pair.
module cla2_slice
    import cla2_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic          cin_i,
    output logic [SW-1:0] sum_o,
    output gp_pair_t      pair_o
);
    logic [SW-1:0] bit_gen_d;
    logic [SW-1:0] bit_prop_d;
    logic [SW-1:0] carry_d;
    logic          gg_d;
    logic          gp_d;

    assign bit_gen_d  = a_i & b_i;
    assign bit_prop_d = a_i | b_i;

    cla2_lcu #(.N(SW)) u_lcu (
        .gen_i      (bit_gen_d),
        .prop_i     (bit_prop_d),
        .cin_i      (cin_i),
        .carry_o    (carry_d),
        .grp_gen_o  (gg_d),
        .grp_prop_o (gp_d)
    );

    assign sum_o       = a_i ^ b_i ^ carry_d;
    assign pair_o.gen  = gg_d;
    assign pair_o.prop = gp_d;
endmodule

// File: rtl/cla2_adder.sv
// Two-level lookahead adder: slices in parallel, group unit feeds slice carries.
module cla2_adder
    import cla2_pkg::*;
#(
    parameter int SLICE_W = 4,
    parameter int N_SLICE = 4
) (
    input  logic [SLICE_W*N_SLICE-1:0] a_in,
    input  logic [SLICE_W*N_SLICE-1:0] b_in,
    input  logic                       c_in,
    output logic [SLICE_W*N_SLICE-1:0] sum_o,
    output logic                       c_out,
    output logic                       grp_gen,
    output logic                       grp_prop
);
    localparam int W = SLICE_W * N_SLICE;

    gp_pair_t     pair_d [N_SLICE];
    logic [N_SLICE-1:0] slice_gen;
    logic [N_SLICE-1:0] slice_prop;
    logic [N_SLICE-1:0] slice_cin;
    logic         gg_d;
    logic         gp_d;

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        cla2_slice #(.SW(SLICE_W)) u_slice (
            .a_i    (a_in[s*SLICE_W +: SLICE_W]),
            .b_i    (b_in[s*SLICE_W +: SLICE_W]),
            .cin_i  (slice_cin[s]),
            .sum_o  (sum_o[s*SLICE_W +: SLICE_W]),
            .pair_o (pair_d[s])
        );
        assign slice_gen[s]  = pair_d[s].gen;
        assign slice_prop[s] = pair_d[s].prop;
    end

    cla2_lcu #(.N(N_SLICE)) u_group (
        .gen_i      (slice_gen),
        .prop_i     (slice_prop),
        .cin_i      (c_in),
        .carry_o    (slice_cin),
        .grp_gen_o  (gg_d),
        .grp_prop_o (gp_d)
    );

    assign grp_gen  = gg_d;
    assign grp_prop = gp_d;
    assign c_out    = gg_d | (gp_d & c_in);

    if (W < 2) begin : g_bad_cfg
        initial $error("cla2_adder: width must be at least 2");
    end
endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
    parameter int SLICE_W = 4,
    parameter int N_SLICE = 4
) (
    input logic [SLICE_W*N_SLICE-1:0] a_in,
    input logic [SLICE_W*N_SLICE-1:0] b_in,
    input logic                       c_in,
    input logic [SLICE_W*N_SLICE-1:0] sum_o,
    input logic                       c_out,
    input logic                       grp_gen,
    input logic                       grp_prop,
    input logic [N_SLICE-1:0]         slice_cin
);
    localparam int W = SLICE_W * N_SLICE;

    logic [W:0] tot_c;
    logic [W:0] tot_nc;

    assign tot_c  = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};
    assign tot_nc = {1'b0, a_in} + {1'b0, b_in};

    always_comb begin
        if (!$isunknown({a_in, b_in, c_in, sum_o, c_out, grp_gen, grp_prop, slice_cin})) begin
            assert_sum_R1: assert (sum_o == tot_c[W-1:0]);
            assert_cout_R2: assert (c_out == tot_c[W]);
            assert_ggen_R3: assert (grp_gen == tot_nc[W]);
            assert_gprop_R4: assert (grp_prop == &(a_in | b_in));
            assert_cout_form_R5: assert (c_out == (grp_gen | (grp_prop & c_in)));
            for (int s = 1; s < N_SLICE; s++) begin
                logic [W:0] lo_mask;
                logic [W:0] lo_sum;
                lo_mask = ({{W{1'b0}}, 1'b1} << (s * SLICE_W)) - 1'b1;
                lo_sum  = ({1'b0, a_in} & lo_mask) + ({1'b0, b_in} & lo_mask)
                        + {{W{1'b0}}, c_in};
                assert_slice_cin_R6: assert (slice_cin[s] == lo_sum[s * SLICE_W]);
            end
        end
    end
endmodule

bind cla2_adder cla2_adder_chk #(.SLICE_W(SLICE_W), .N_SLICE(N_SLICE)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .c_in      (c_in),
    .sum_o     (sum_o),
    .c_out     (c_out),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .slice_cin (slice_cin)
);

// File: tb/cla2_adder_tb.sv
module cla2_adder_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] a, b, f;
    logic        ci, co, gg, gp;
    logic [3:0]  sa, sb, sf;
    logic        sci, sco, sgg, sgp;

    cla2_adder u_dut (
        .a_in(a), .b_in(b), .c_in(ci),
        .sum_o(f), .c_out(co), .grp_gen(gg), .grp_prop(gp)
    );

    cla2_adder #(.SLICE_W(2), .N_SLICE(2)) u_dut_small (
        .a_in(sa), .b_in(sb), .c_in(sci),
        .sum_o(sf), .c_out(sco), .grp_gen(sgg), .grp_prop(sgp)
    );

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h c=%b)", tag, act, exp, a, b, ci);
        end
    endtask

    // full-width vector: drive after posedge, check at negedge
    task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic c);
        logic [16:0] t, tn;
        @(posedge clk);
        a = x; b = y; ci = c;
        @(negedge clk);
        t  = {1'b0, x} + {1'b0, y} + {16'd0, c};
        tn = {1'b0, x} + {1'b0, y};
        chk("R1 sum", {1'b0, f}, {1'b0, t[15:0]});
        chk("R2 carry out", {16'd0, co}, {16'd0, t[16]});
        chk("R3 group gen", {16'd0, gg}, {16'd0, tn[16]});
        chk("R4 group prop", {16'd0, gp}, {16'd0, &(x | y)});
        chk("R5 cout form", {16'd0, co}, {16'd0, gg | (gp & c)});
    endtask

    task automatic run4(input logic [3:0] x, input logic [3:0] y, input logic c);
        logic [4:0] t, tn;
        @(posedge clk);
        sa = x; sb = y; sci = c;
        @(negedge clk);
        t  = {1'b0, x} + {1'b0, y} + {4'd0, c};
        tn = {1'b0, x} + {1'b0, y};
        chk("R1 small sum", {13'd0, sf}, {13'd0, t[3:0]});
        chk("R2 small carry", {16'd0, sco}, {16'd0, t[4]});
        chk("R3 small gen", {16'd0, sgg}, {16'd0, tn[4]});
        chk("R4 small prop", {16'd0, sgp}, {16'd0, &(x | y)});
        // R6: bit 2 of the sum shows the carry handed into the upper slice
        chk("R6 small slice carry", {16'd0, sf[2]},
            {16'd0, x[2] ^ y[2] ^ (({3'b0, x[1:0]} + {3'b0, y[1:0]} + {4'd0, c}) >> 2)});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        sa = '0; sb = '0; sci = 1'b0;
        // idle state: all-zero inputs
        @(negedge clk);
        chk("R1 idle sum", {1'b0, f}, 17'd0);
        chk("R2 idle carry", {16'd0, co}, 17'd0);

        // R7 full-word propagate paths
        run16(16'hFFFF, 16'h0000, 1'b0);
        chk("R7 no carry-in", {co, f}, {1'b0, 16'hFFFF});
        run16(16'hFFFF, 16'h0000, 1'b1);
        chk("R7 carry-in crosses word", {co, f}, {1'b1, 16'h0000});
        // R2 longest carry path: all-ones + 1
        run16(16'hFFFF, 16'h0001, 1'b0);
        chk("R2 all-ones plus one", {co, f}, {1'b1, 16'h0000});
        // R6 slice boundaries
        run16(16'h000F, 16'h0001, 1'b0);
        chk("R6 boundary 4", {co, f}, {1'b0, 16'h0010});
        run16(16'h00FF, 16'h0000, 1'b1);
        chk("R6 boundary 8", {co, f}, {1'b0, 16'h0100});
        run16(16'h0F0F, 16'h00F1, 1'b0);
        chk("R6 boundary 12", {co, f}, {1'b0, 16'h1000});
        run16(16'h8000, 16'h8000, 1'b0);
        run16(16'hAAAA, 16'h5555, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            run16(16'($urandom), 16'($urandom), 1'($urandom));
        end

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    run4(4'(x), 4'(y), 1'(c));
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule